// File: doc/BRIEF.md
# Digital Video Output Formatter with Viewport

This block builds the 4:2:2 digital video raster for a display running either 525-line or 625-line timing, and places a decoded picture inside it at a programmable offset. It counts samples, lines and fields. It drives horizontal sync, vertical sync, field and data-enable outputs. It pulls picture samples from an upstream source through a valid/ready handshake, and it does so only while the raster position lies inside the picture window. The line standard of the display and the line count of the source picture are selected independently. A negative vertical offset crops a tall picture, and a positive offset puts a border around a short one.

The block runs at the byte rate, so each sample takes two clocks. In word mode it presents one 16-bit word per sample, with luma in the upper byte and chroma in the lower byte, and pulses a strobe on the first clock of the sample. In byte mode it emits one byte per clock as a chroma/luma multiplex. This stream carries four-byte timing reference codes before and after the active part of every line. Source samples whose window position falls in blanking are still taken from the source and then thrown away. This keeps the source in step with the raster. Standard, mode and viewport are taken over once per frame.

Top module: `vo_formatter`

## Requirements
- R1: While rst_n is low, dout, word_stb, de, hsync, vsync and field are all 0 and src_ready is 0 (with a non-negative vertical offset).
- R2: Each sample lasts two clocks. A line has H_TOT_625 samples when the display standard is 625 and H_TOT_525 samples otherwise. A frame is field 0 followed by field 1. Field 1 has FLD_x lines and field 0 has one line more. hsync is high for samples H_ACTIVE to H_ACTIVE+HSYNC_W-1, vsync is high on field lines 0 to VSYNC_L-1, and field shows the current field. All outputs lag the raster position by one clock.
- R3: de is high exactly on samples 0 to H_ACTIVE-1 of lines at or after the field's blanking count. The blanking count is VBL_x for field 1 and VBL_x+1 for field 0.
- R4: In word mode, word_stb pulses on the first clock of each sample and dout = {Y, C}. dout holds its value on the second clock. Blanking and black are Y=0x10, C=0x80.
- R5: In byte mode, word_stb stays 0 and dout[15:8] = 0. Each sample gives its chroma byte and then its luma byte, so a sample pair gives U, Y, V, Y. In blanking the bytes are 0x80 and 0x10.
- R6: In byte mode, samples H_ACTIVE and H_ACTIVE+1 carry the end code and the last two samples of the line carry the start code. Each code is the bytes FF, 00, 00, S with S = {1, F, V, H, V^H, F^H, F^V, F^V^H}. F is the field, V is 1 on blanking lines, and H is 1 for the end code.
- R7: src_ready is high only on the first clock of a sample inside the window. The window is column h - X in [0, PIC_W) and row line - blank - Y in [0, P), where X is vp_x with bit 0 cleared and Y is vp_y taken as two's complement.
- R8: An active sample that is inside the window and accepted shows the source Y and C. An active sample outside the window shows black. Bit 0 of vp_x has no effect.
- R9: An active window sample with src_valid low shows black, and that sample slot is not retried.
- R10: Window samples that land on blanking lines or past the active samples of a line are still requested, and they are not shown.
- R11: The display standard, source standard, mode and offsets take effect only at frame start (field 0, line 0, sample 0). A change made mid-frame leaves the line length unchanged until then.
- R12: P is PIC_L_625 when src_625 is 1 and PIC_L_525 otherwise, independent of disp_625. A fully enclosed window requests 2*PIC_W*P samples per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_625 | input | 1 | Display standard: 1 = 625-line, 0 = 525-line |
| src_625 | input | 1 | Source picture standard: 1 = 625-line, 0 = 525-line |
| byte_mode | input | 1 | 1 = 8-bit multiplexed output, 0 = 16-bit words |
| vp_x | input | HW | Horizontal viewport offset in samples (bit 0 ignored) |
| vp_y | input | VW | Vertical viewport offset in lines, two's complement |
| src_valid | input | 1 | Upstream sample available |
| src_ready | output | 1 | Request for one upstream sample |
| src_y | input | 8 | Upstream luma |
| src_c | input | 8 | Upstream chroma (U on even, V on odd samples) |
| dout | output | 16 | Video word, or the byte in the low half |
| word_stb | output | 1 | New word in word mode |
| de | output | 1 | Active video sample |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| field | output | 1 | Current field |

## Verification
The bench builds the formatter with 16 active samples, line totals of 22 and 24 samples, fields of 8 and 10 lines with 3 and 4 blanking lines, and a 12-sample picture of 5 or 6 lines. With these values a whole frame takes about a thousand clocks, so many frame boundaries, mode switches and configuration changes fit into one run. A vertical offset of a single line is enough to push picture rows into blanking or past the bottom of the field. A modest horizontal offset pushes picture samples past the active region and into the timing codes.

// File: rtl/vo_pkg.sv
package vo_pkg;

    localparam logic [7:0] BLACK_Y = 8'h10;
    localparam logic [7:0] BLACK_C = 8'h80;

    // Status byte of a timing reference code with its protection bits.
    function automatic logic [7:0] trs_status(input logic fld, input logic vbl, input logic eav);
        return {1'b1, fld, vbl, eav, vbl ^ eav, fld ^ eav, fld ^ vbl, fld ^ vbl ^ eav};
    endfunction

endpackage

// File: rtl/vo_raster.sv
module vo_raster #(
    parameter int H_TOT_525 = 858,
    parameter int H_TOT_625 = 864,
    parameter int FLD_525   = 262,
    parameter int FLD_625   = 312,
    parameter int VBL_525   = 22,
    parameter int VBL_625   = 24,
    parameter int HW        = 10,
    parameter int LW        = 9,
    parameter int VW        = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_disp625,
    input  logic          cfg_src625,
    input  logic          cfg_byte,
    input  logic [HW-1:0] cfg_vpx,
    input  logic [VW-1:0] cfg_vpy,
    output logic          phase,
    output logic [HW-1:0] h,
    output logic [HW-1:0] h_end,
    output logic [LW-1:0] line,
    output logic [LW-1:0] vbl_len,
    output logic          field,
    output logic          eff_src625,
    output logic          eff_byte,
    output logic [HW-1:0] eff_vpx,
    output logic [VW-1:0] eff_vpy
);

    typedef struct packed {
        logic          disp625;
        logic          src625;
        logic          bmode;
        logic [HW-1:0] vpx;
        logic [VW-1:0] vpy;
    } cfg_t;

    typedef struct packed {
        logic          phase;
        logic [HW-1:0] h;
        logic [LW-1:0] line;
        logic          field;
        cfg_t          cfg;
    } raster_t;

    raster_t       q, d;
    cfg_t          cfg_in, cfg_eff;
    logic          at_start;
    logic [LW-1:0] l_end;
    logic [LW-1:0] extra;

    always_comb begin
        cfg_in.disp625 = cfg_disp625;
        cfg_in.src625  = cfg_src625;
        cfg_in.bmode   = cfg_byte;
        cfg_in.vpx     = cfg_vpx;
        cfg_in.vpy     = cfg_vpy;

        at_start = !q.field && (q.line == '0) && (q.h == '0) && !q.phase;
        cfg_eff  = at_start ? cfg_in : q.cfg;

        extra   = {{(LW-1){1'b0}}, ~q.field};
        h_end   = cfg_eff.disp625 ? HW'(H_TOT_625 - 1) : HW'(H_TOT_525 - 1);
        l_end   = (cfg_eff.disp625 ? LW'(FLD_625 - 1) : LW'(FLD_525 - 1)) + extra;
        vbl_len = (cfg_eff.disp625 ? LW'(VBL_625) : LW'(VBL_525)) + extra;

        d       = q;
        d.cfg   = cfg_eff;
        d.phase = !q.phase;
        if (q.phase) begin
            if (q.h == h_end) begin
                d.h = '0;
                if (q.line == l_end) begin
                    d.line  = '0;
                    d.field = !q.field;
                end else begin
                    d.line = q.line + 1'b1;
                end
            end else begin
                d.h = q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phase      = q.phase;
    assign h          = q.h;
    assign line       = q.line;
    assign field      = q.field;
    assign eff_src625 = cfg_eff.src625;
    assign eff_byte   = cfg_eff.bmode;
    assign eff_vpx    = cfg_eff.vpx;
    assign eff_vpy    = cfg_eff.vpy;

endmodule

// File: rtl/vo_window.sv
module vo_window #(
    parameter int H_ACTIVE  = 720,
    parameter int PIC_W     = 704,
    parameter int PIC_L_525 = 240,
    parameter int PIC_L_625 = 288,
    parameter int HW        = 10,
    parameter int LW        = 9,
    parameter int VW        = 10
) (
    input  logic          phase,
    input  logic [HW-1:0] h,
    input  logic [LW-1:0] line,
    input  logic [LW-1:0] vbl_len,
    input  logic          src625,
    input  logic [HW-1:0] vpx,
    input  logic [VW-1:0] vpy,
    output logic          req,
    output logic          active,
    output logic          vblank
);

    logic [HW-1:0]          x0;
    logic [HW:0]            col_off;
    logic signed [VW+1:0]   row_off;
    logic signed [VW+1:0]   pic_l;
    logic                   in_col, in_row;

    always_comb begin
        x0      = {vpx[HW-1:1], 1'b0};
        col_off = {1'b0, h} - {1'b0, x0};
        in_col  = (h >= x0) && (col_off < (HW+1)'(PIC_W));

        pic_l   = src625 ? (VW+2)'(PIC_L_625) : (VW+2)'(PIC_L_525);
        row_off = $signed({3'b000, line}) - $signed({3'b000, vbl_len})
                - $signed({{2{vpy[VW-1]}}, vpy});
        in_row  = (row_off >= 0) && (row_off < pic_l);

        vblank  = line < vbl_len;
        active  = (h < HW'(H_ACTIVE)) && !vblank;
        req     = in_col && in_row && !phase;
    end

endmodule

// File: rtl/vo_pixel_out.sv
module vo_pixel_out
    import vo_pkg::*;
#(
    parameter int H_ACTIVE = 720,
    parameter int HSYNC_W  = 64,
    parameter int VSYNC_L  = 3,
    parameter int HW       = 10,
    parameter int LW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase,
    input  logic [HW-1:0] h,
    input  logic [HW-1:0] h_end,
    input  logic [LW-1:0] line,
    input  logic          field,
    input  logic          vblank,
    input  logic          active,
    input  logic          fire,
    input  logic          bmode,
    input  logic [7:0]    src_y,
    input  logic [7:0]    src_c,
    output logic [15:0]   dout,
    output logic          word_stb,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic          field_o
);

    typedef struct packed {
        logic [15:0] dout;
        logic        stb;
        logic        de;
        logic        hs;
        logic        vs;
        logic        fld;
        logic [7:0]  yhold;
    } out_t;

    out_t       q, d;
    logic [7:0] sy, sc, code_byte;
    logic       eav_hit, sav_hit;
    logic [1:0] code_idx;

    always_comb begin
        if (active && fire) begin
            sy = src_y;
            sc = src_c;
        end else begin
            sy = BLACK_Y;
            sc = BLACK_C;
        end

        eav_hit   = (h == HW'(H_ACTIVE)) || (h == HW'(H_ACTIVE + 1));
        sav_hit   = (h == h_end - 1'b1) || (h == h_end);
        code_idx  = {eav_hit ? (h == HW'(H_ACTIVE + 1)) : (h == h_end), phase};
        code_byte = (code_idx == 2'd0) ? 8'hFF :
                    (code_idx == 2'd3) ? trs_status(field, vblank, eav_hit) : 8'h00;

        d     = q;
        d.stb = 1'b0;
        if (!phase) d.yhold = sy;

        if (bmode) begin
            if (eav_hit || sav_hit) d.dout = {8'h00, code_byte};
            else                    d.dout = {8'h00, phase ? q.yhold : sc};
        end else if (!phase) begin
            d.dout = {sy, sc};
            d.stb  = 1'b1;
        end

        d.de  = active;
        d.hs  = (h >= HW'(H_ACTIVE)) && (h < HW'(H_ACTIVE + HSYNC_W));
        d.vs  = line < LW'(VSYNC_L);
        d.fld = field;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout     = q.dout;
    assign word_stb = q.stb;
    assign de       = q.de;
    assign hsync    = q.hs;
    assign vsync    = q.vs;
    assign field_o  = q.fld;

endmodule

// File: rtl/vo_formatter.sv
module vo_formatter #(
    parameter int H_ACTIVE  = 720,
    parameter int H_TOT_525 = 858,
    parameter int H_TOT_625 = 864,
    parameter int FLD_525   = 262,
    parameter int VBL_525   = 22,
    parameter int FLD_625   = 312,
    parameter int VBL_625   = 24,
    parameter int PIC_W     = 704,
    parameter int PIC_L_525 = 240,
    parameter int PIC_L_625 = 288,
    parameter int HSYNC_W   = 64,
    parameter int VSYNC_L   = 3,
    localparam int H_MAX    = (H_TOT_625 > H_TOT_525) ? H_TOT_625 : H_TOT_525,
    localparam int HW       = $clog2(H_MAX + 1),
    localparam int L_MAX    = ((FLD_625 > FLD_525) ? FLD_625 : FLD_525) + 1,
    localparam int LW       = $clog2(L_MAX + 1),
    localparam int VW       = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_625,
    input  logic          src_625,
    input  logic          byte_mode,
    input  logic [HW-1:0] vp_x,
    input  logic [VW-1:0] vp_y,
    input  logic          src_valid,
    output logic          src_ready,
    input  logic [7:0]    src_y,
    input  logic [7:0]    src_c,
    output logic [15:0]   dout,
    output logic          word_stb,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic          field
);

    logic          phase, fld, src625_eff, byte_eff;
    logic [HW-1:0] h, h_end, vpx_eff;
    logic [LW-1:0] line, vbl_len;
    logic [VW-1:0] vpy_eff;
    logic          req, active, vblank, fire;

    vo_raster #(
        .H_TOT_525(H_TOT_525), .H_TOT_625(H_TOT_625),
        .FLD_525(FLD_525), .FLD_625(FLD_625),
        .VBL_525(VBL_525), .VBL_625(VBL_625),
        .HW(HW), .LW(LW), .VW(VW)
    ) u_raster (
        .clk(clk), .rst_n(rst_n),
        .cfg_disp625(disp_625), .cfg_src625(src_625), .cfg_byte(byte_mode),
        .cfg_vpx(vp_x), .cfg_vpy(vp_y),
        .phase(phase), .h(h), .h_end(h_end), .line(line), .vbl_len(vbl_len),
        .field(fld), .eff_src625(src625_eff), .eff_byte(byte_eff),
        .eff_vpx(vpx_eff), .eff_vpy(vpy_eff)
    );

    vo_window #(
        .H_ACTIVE(H_ACTIVE), .PIC_W(PIC_W),
        .PIC_L_525(PIC_L_525), .PIC_L_625(PIC_L_625),
        .HW(HW), .LW(LW), .VW(VW)
    ) u_window (
        .phase(phase), .h(h), .line(line), .vbl_len(vbl_len),
        .src625(src625_eff), .vpx(vpx_eff), .vpy(vpy_eff),
        .req(req), .active(active), .vblank(vblank)
    );

    assign src_ready = req;
    assign fire      = req && src_valid;

    vo_pixel_out #(
        .H_ACTIVE(H_ACTIVE), .HSYNC_W(HSYNC_W), .VSYNC_L(VSYNC_L),
        .HW(HW), .LW(LW)
    ) u_out (
        .clk(clk), .rst_n(rst_n),
        .phase(phase), .h(h), .h_end(h_end), .line(line), .field(fld),
        .vblank(vblank), .active(active), .fire(fire), .bmode(byte_eff),
        .src_y(src_y), .src_c(src_c),
        .dout(dout), .word_stb(word_stb), .de(de),
        .hsync(hsync), .vsync(vsync), .field_o(field)
    );

endmodule

// File: rtl/vo_formatter_chk.sv
module vo_formatter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        src_ready,
    input logic        word_stb,
    input logic        de,
    input logic        hsync,
    input logic        vsync,
    input logic        field,
    input logic [15:0] dout
);

    // R7: a request lasts a single clock per sample
    p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |=> !src_ready);

    // R4: one word strobe per two-clock sample
    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    // R4: a word outside active video is black
    p_blank_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !de) |-> (dout == 16'h1080));

    // R2: field only toggles while vertical sync is shown
    p_field_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (field != $past(field)) |-> vsync);

    // R3: active video never overlaps a sync interval
    p_de_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));

endmodule

bind vo_formatter vo_formatter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .word_stb(word_stb),
    .de(de), .hsync(hsync), .vsync(vsync), .field(field), .dout(dout)
);

// File: tb/vo_formatter_bench.sv
module vo_formatter_bench;

    localparam int HA = 16, HT5 = 22, HT6 = 24, F5 = 8, F6 = 10, B5 = 3, B6 = 4;
    localparam int PW = 12, PL5 = 5, PL6 = 6, HSW = 2, VSL = 2;
    localparam int HW = 5, VW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          disp_625 = 0, src_625 = 0, byte_mode = 0, src_valid = 0;
    logic [HW-1:0] vp_x = '0;
    logic [VW-1:0] vp_y = '0;
    logic [7:0]    src_y = '0, src_c = '0;
    logic          src_ready, word_stb, de, hsync, vsync, field;
    logic [15:0]   dout;

    vo_formatter #(
        .H_ACTIVE(HA), .H_TOT_525(HT5), .H_TOT_625(HT6),
        .FLD_525(F5), .VBL_525(B5), .FLD_625(F6), .VBL_625(B6),
        .PIC_W(PW), .PIC_L_525(PL5), .PIC_L_625(PL6),
        .HSYNC_W(HSW), .VSYNC_L(VSL)
    ) u_vo_formatter (
        .clk(clk), .rst_n(rst_n), .disp_625(disp_625), .src_625(src_625),
        .byte_mode(byte_mode), .vp_x(vp_x), .vp_y(vp_y),
        .src_valid(src_valid), .src_ready(src_ready), .src_y(src_y), .src_c(src_c),
        .dout(dout), .word_stb(word_stb), .de(de), .hsync(hsync),
        .vsync(vsync), .field(field)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    // configuration requested by the stimulus, applied at the next drive point
    bit n_d6 = 0, n_s6 = 0, n_bm = 0;
    int n_vpx = 0, n_vpy = 0, vrate = 100;

    // reference model state
    int  m_ph = 0, m_h = 0, m_line = 0, m_fld = 0;
    bit  m_d6, m_s6, m_bm;
    int  m_vpx, m_vpy;
    int  m_yhold = 16;
    logic [15:0] e_dout = '0;
    bit  e_stb, e_de, e_hs, e_vs, e_fld, e_valid = 0;
    string e_tag = "R4", m_ptag = "R4";
    int  frames_seen = 0, rdy_cnt = 0;
    int  last_rise = -1, last_period = 0;
    bit  prev_hs = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int status_byte(int f, int v, int e);
        return 128 + 64*f + 32*v + 16*e + 8*(v ^ e) + 4*(f ^ e) + 2*(f ^ v) + (f ^ v ^ e);
    endfunction

    task automatic model_eval();
        int htot, flen, vbl, pl, row, col, y, c, b, k;
        bit win, act, rdy, fire, eav, sav;
        if (m_fld == 0 && m_line == 0 && m_h == 0 && m_ph == 0) begin
            m_d6 = disp_625; m_s6 = src_625; m_bm = byte_mode;
            m_vpx = int'(vp_x) & ~1;
            m_vpy = $signed(vp_y);
            frames_seen++;
        end
        htot = m_d6 ? HT6 : HT5;
        flen = (m_d6 ? F6 : F5) + (m_fld == 0 ? 1 : 0);
        vbl  = (m_d6 ? B6 : B5) + (m_fld == 0 ? 1 : 0);
        pl   = m_s6 ? PL6 : PL5;
        row  = m_line - vbl - m_vpy;
        col  = m_h - m_vpx;
        win  = (row >= 0) && (row < pl) && (col >= 0) && (col < PW);
        act  = (m_h < HA) && (m_line >= vbl);
        rdy  = win && (m_ph == 0);
        chk(src_ready === rdy, (win && !act) ? "R10" : (m_s6 != m_d6) ? "R12" : "R7",
            "src_ready", src_ready, rdy);
        if (src_ready) rdy_cnt++;
        fire = rdy && src_valid;
        if (act && fire) begin y = src_y; c = src_c; end
        else begin y = 16; c = 128; end
        if (m_ph == 0)
            m_ptag = !act ? (m_bm ? "R5" : "R4") : (win ? (src_valid ? "R8" : "R9") : "R8");
        e_hs  = (m_h >= HA) && (m_h < HA + HSW);
        e_vs  = m_line < VSL;
        e_fld = m_fld[0];
        e_de  = act;
        if (!m_bm) begin
            e_tag = m_ptag;
            if (m_ph == 0) begin e_dout = {8'(y), 8'(c)}; e_stb = 1; end
            else e_stb = 0;
        end else begin
            e_stb = 0;
            eav = (m_h == HA) || (m_h == HA + 1);
            sav = (m_h == htot - 2) || (m_h == htot - 1);
            if (eav || sav) begin
                k = 2 * (eav ? m_h - HA : m_h - (htot - 2)) + m_ph;
                b = (k == 0) ? 255 : (k == 3) ? status_byte(m_fld, m_line < vbl, eav) : 0;
                e_tag = "R6";
            end else begin
                b = (m_ph == 0) ? c : m_yhold;
                e_tag = m_ptag;
            end
            e_dout = {8'h00, 8'(b)};
        end
        if (m_ph == 0) m_yhold = y;
        if (m_ph == 1) begin
            if (m_h == htot - 1) begin
                m_h = 0;
                if (m_line == flen - 1) begin m_line = 0; m_fld ^= 1; end
                else m_line++;
            end else m_h++;
        end
        m_ph ^= 1;
        e_valid = 1;
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (e_valid) begin
            chk({word_stb, dout} === {e_stb, e_dout}, e_tag, "video", {word_stb, dout}, {e_stb, e_dout});
            chk({hsync, vsync, field} === {e_hs, e_vs, e_fld}, "R2", "sync", {hsync, vsync, field},
                {e_hs, e_vs, e_fld});
            chk(de === e_de, "R3", "de", de, e_de);
        end
        if (hsync && !prev_hs) begin
            if (last_rise >= 0) last_period = cyc - last_rise;
            last_rise = cyc;
        end
        prev_hs = hsync;
        rst_n     = 1'b1;
        disp_625  = n_d6;
        src_625   = n_s6;
        byte_mode = n_bm;
        vp_x      = HW'(n_vpx);
        vp_y      = VW'(n_vpy);
        src_valid = ($urandom_range(99) < vrate);
        src_y     = 8'($urandom);
        src_c     = 8'($urandom);
        #1;
        model_eval();
    endtask

    task automatic run_to_frame();
        int f = frames_seen;
        while (frames_seen == f) step();
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_cfg(input bit d6, input bit s6, input bit bm, input int x, input int y);
        n_d6 = d6; n_s6 = s6; n_bm = bm; n_vpx = x; n_vpy = y;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(dout === 16'h0 && word_stb === 1'b0, "R1", "reset video", {word_stb, dout}, 0);
        chk({de, hsync, vsync, field} === 4'b0, "R1", "reset timing", {de, hsync, vsync, field}, 0);
        chk(src_ready === 1'b0, "R1", "reset ready", src_ready, 0);

        // first frame: word mode, matching standards, full handshake
        set_cfg(0, 0, 0, 2, 0); vrate = 100;
        run_to_frame();
        run_to_frame();
        // byte mode with an odd horizontal offset (bit 0 must not matter) and gaps
        set_cfg(0, 0, 1, 3, 0); vrate = 80;
        run_to_frame();
        // tall source on short display, one line cropped at the top
        set_cfg(0, 1, 0, 0, -1); vrate = 100;
        run_to_frame();
        // short source on tall display with border: count requests over one frame
        set_cfg(1, 0, 1, 4, 1);
        run_to_frame();
        rdy_cnt = 0;
        run_to_frame();
        chk(rdy_cnt == 2 * PW * PL5, "R12", "requests per frame", rdy_cnt, 2 * PW * PL5);
        // picture running past the active samples into horizontal blanking
        set_cfg(0, 0, 1, 10, 0); vrate = 70;
        run_to_frame();
        // mid-frame standard change must wait for the frame start
        set_cfg(0, 0, 0, 0, 0);
        run_to_frame();
        run_cycles(4 * 2 * HT5);
        n_d6 = 1;
        run_cycles(3 * 2 * HT5);
        chk(last_period == 2 * HT5, "R11", "line period mid-frame", last_period, 2 * HT5);
        run_to_frame();
        run_cycles(3 * 2 * HT6);
        chk(last_period == 2 * HT6, "R11", "line period next frame", last_period, 2 * HT6);

        // constrained random frames with occasional mid-frame reprogramming
        for (int f = 0; f < 10; f++) begin
            vrate = 50 + $urandom_range(50);
            set_cfg($urandom_range(1), $urandom_range(1), $urandom_range(1),
                    $urandom_range(HA), int'($urandom_range(6)) - 3);
            run_cycles(50 + $urandom_range(300));
            if ($urandom_range(1)) set_cfg($urandom_range(1), $urandom_range(1), $urandom_range(1),
                                           $urandom_range(HA), int'($urandom_range(6)) - 3);
            run_to_frame();
        end
        run_to_frame();
        summary();
    end

endmodule